// File: doc/BRIEF.md
# Byte-to-Word Card Data FIFO Engine

This block sits between a card's byte-wide data port and a host that moves 32-bit words. It holds a 16-word circular FIFO. When data flows from the card, it packs incoming bytes into words, least significant byte first. When data flows to the card, it splits each word into bytes, least significant byte first. A 16-bit byte counter is loaded from a programmed length. The transfer ends when that counter reaches zero. A short final word is padded with zero upper bytes.

The host reaches the block through a small register port with five selections: length, control, status, word count and FIFO. It reads flags that depend on the transfer direction. Each host pop from the FIFO sets a defer flag. Card traffic then pauses until the host reads status or the word count, so the FIFO never changes under a host that is still draining it. The card's serial signalling, CRC and DMA live elsewhere.

Top module: `card_fifo_engine`

## Requirements
- R1: The FIFO holds 16 words of 32 bits in a circular buffer, and its fill level never exceeds 16. A push into a full FIFO or a pop from an empty one leaves its contents and order unchanged.
- R2: In card-to-host mode, each byte taken from the card fills the next byte lane of a word, starting at bits 7:0. The word enters the FIFO when its fourth byte arrives.
- R3: If the byte counter runs out partway through a word, that partial word is pushed with its unfilled upper bytes set to zero.
- R4: In host-to-card mode, one byte per cycle is presented on `card_tx_byte` with `card_tx_valid`, starting from bits 7:0 of each popped word. Output stops as soon as the counter reaches zero, and leftover bytes of that word are dropped.
- R5: Host select codes are 0 length, 1 control, 2 status, 3 word count and 4 FIFO. The length register keeps only bits 15:0 of a write. Writing control with bit 0 (enable) set loads the counter from the length and clears the defer flag. Control bit 1 selects the direction, where 1 means card-to-host. A control read returns {direction, enable} in bits 1:0. Each transferred byte lowers the counter by one.
- R6: A byte is taken from the card only in a cycle where `card_rdy` is high and the FIFO is not full.
- R7: When the counter is zero during a transfer, status bits 0 (transfer end) and 1 (block end) become set. They stay set until the next enabling control write. The enable bit clears by itself once the counter is zero and the FIFO is empty.
- R8: While enable is set, the status register shows flags for the active direction only. Transmit flags are bit 2 active, bit 3 half-empty (8 or fewer words), bit 4 full, bit 5 empty and bit 6 data available. Receive flags are bit 7 active, bit 8 half-full (8 or more words), bit 9 full, bit 10 empty and bit 11 data available. All flags read 0 while enable is clear.
- R9: A successful host FIFO pop sets the defer flag, which blocks all card transfers. A status or word-count read clears the flag, and that read returns the value from before the transfer resumes.
- R10: A word-count read returns (counter + 3) >> 2.
- R11: A host FIFO write is ignored while the counter is zero or the direction is card-to-host. A host FIFO read of an empty FIFO returns 0.
- R12: `fifo_err` is high for exactly the one cycle after a host pop of an empty FIFO, or after a host-to-card push into a full FIFO. At all other times it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe; side effects apply at the clock edge |
| host_addr | input | 3 | Register select |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read data for the current select, combinational |
| card_rdy | input | 1 | Card has a byte ready |
| card_rx_byte | input | 8 | Byte from the card |
| card_rx_take | output | 1 | Byte on card_rx_byte is consumed at this edge |
| card_tx_valid | output | 1 | card_tx_byte is sent at this edge |
| card_tx_byte | output | 8 | Byte to the card |
| fifo_err | output | 1 | One-cycle pulse after a rejected FIFO access |

## Verification
The bound checker watches several rules on every cycle:
- the fill level stays within its bound;
- no byte moves while the defer flag is set, or from a card that is not ready, or into a full FIFO;
- the counter drops by exactly one per transferred byte;
- the enable bit clears once the counter and the FIFO are both empty;
- the error pulse follows an empty pop.

Only the bench's scenarios can show the byte ordering inside words, the zero padding of a short word and the bytes dropped at the end of a transmit. The same holds for the exact status encodings at empty, half and full, and for the fact that a resuming status read returns the value from before the resume.

// File: rtl/cfe_pkg.sv
package cfe_pkg;
    localparam int SEL_W = 3;
    localparam logic [SEL_W-1:0] SEL_LEN  = 3'd0;
    localparam logic [SEL_W-1:0] SEL_CTRL = 3'd1;
    localparam logic [SEL_W-1:0] SEL_STAT = 3'd2;
    localparam logic [SEL_W-1:0] SEL_WCNT = 3'd3;
    localparam logic [SEL_W-1:0] SEL_FIFO = 3'd4;

    localparam int STAT_W      = 12;
    localparam int ST_END      = 0;
    localparam int ST_BLK      = 1;
    localparam int ST_TX_ACT   = 2;
    localparam int ST_TX_HEMP  = 3;
    localparam int ST_TX_FULL  = 4;
    localparam int ST_TX_EMPTY = 5;
    localparam int ST_TX_AVAIL = 6;
    localparam int ST_RX_ACT   = 7;
    localparam int ST_RX_HFULL = 8;
    localparam int ST_RX_FULL  = 9;
    localparam int ST_RX_EMPTY = 10;
    localparam int ST_RX_AVAIL = 11;
endpackage

// File: rtl/cfe_word_ring.sv
module cfe_word_ring #(
    parameter int DEPTH  = 16,
    parameter int WORD_W = 32,
    parameter int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [WORD_W-1:0] push_word,
    input  logic              pop,
    output logic [WORD_W-1:0] head,
    output logic [CNT_W-1:0]  fill,
    output logic              full,
    output logic              empty
);
    localparam int PTR_W = $clog2(DEPTH);

    typedef struct packed {
        logic [PTR_W-1:0] rd_ptr;
        logic [CNT_W-1:0] fill;
    } ring_t;

    ring_t ring_d, ring_q;
    logic [WORD_W-1:0] mem_q [DEPTH];
    logic [PTR_W-1:0]  wr_slot;
    logic              push_ok, pop_ok;

    always_comb begin
        full    = (ring_q.fill == CNT_W'(DEPTH));
        empty   = (ring_q.fill == '0);
        push_ok = push && !full;
        pop_ok  = pop && !empty;
        wr_slot = PTR_W'((32'(ring_q.rd_ptr) + 32'(ring_q.fill)) % DEPTH);
        head    = mem_q[ring_q.rd_ptr];
        fill    = ring_q.fill;

        ring_d = ring_q;
        if (pop_ok) begin
            ring_d.rd_ptr = PTR_W'((32'(ring_q.rd_ptr) + 1) % DEPTH);
        end
        ring_d.fill = ring_q.fill + CNT_W'(push_ok) - CNT_W'(pop_ok);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ring_q <= '0;
        else        ring_q <= ring_d;
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem_q[wr_slot] <= push_word;
    end
endmodule

// File: rtl/cfe_packer.sv
module cfe_packer #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              step,
    input  logic              last,
    input  logic [7:0]        byte_in,
    output logic              push,
    output logic [WORD_W-1:0] word
);
    localparam int LANES = WORD_W / 8;
    localparam int IDX_W = (LANES > 1) ? $clog2(LANES) : 1;

    typedef struct packed {
        logic [WORD_W-1:0] acc;
        logic [IDX_W-1:0]  idx;
    } pack_t;

    pack_t pk_d, pk_q;

    always_comb begin
        word = pk_q.acc | (WORD_W'(byte_in) << {pk_q.idx, 3'b000});
        push = step && (last || (pk_q.idx == IDX_W'(LANES - 1)));

        pk_d = pk_q;
        if (clear) begin
            pk_d = '0;
        end else if (step) begin
            if (push) begin
                pk_d = '0;
            end else begin
                pk_d.acc = word;
                pk_d.idx = pk_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pk_q <= '0;
        else        pk_q <= pk_d;
    end
endmodule

// File: rtl/cfe_unpacker.sv
module cfe_unpacker #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              step,
    input  logic              last,
    input  logic [WORD_W-1:0] word_in,
    output logic              need_word,
    output logic              has_bytes,
    output logic [7:0]        byte_out
);
    localparam int LANES = WORD_W / 8;
    localparam int LEFT_W = $clog2(LANES);

    typedef struct packed {
        logic [WORD_W-1:0] shreg;
        logic [LEFT_W-1:0] left;
    } unpack_t;

    unpack_t up_d, up_q;

    always_comb begin
        need_word = (up_q.left == '0);
        has_bytes = !need_word;
        byte_out  = need_word ? word_in[7:0] : up_q.shreg[7:0];

        up_d = up_q;
        if (clear) begin
            up_d = '0;
        end else if (step) begin
            if (last) begin
                up_d = '0;
            end else if (need_word) begin
                up_d.shreg = word_in >> 8;
                up_d.left  = LEFT_W'(LANES - 1);
            end else begin
                up_d.shreg = up_q.shreg >> 8;
                up_d.left  = up_q.left - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) up_q <= '0;
        else        up_q <= up_d;
    end
endmodule

// File: rtl/cfe_status.sv
module cfe_status
    import cfe_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              en,
    input  logic              to_host,
    input  logic              done,
    input  logic [CNT_W-1:0]  fill,
    output logic [STAT_W-1:0] flags
);
    localparam int HALF = DEPTH / 2;

    logic f_empty, f_avail, f_full, f_hemp, f_hfull;

    always_comb begin
        f_empty = (fill == '0);
        f_avail = !f_empty;
        f_full  = (fill == CNT_W'(DEPTH));
        f_hemp  = (fill <= CNT_W'(HALF));
        f_hfull = (fill >= CNT_W'(HALF));

        flags         = '0;
        flags[ST_END] = done;
        flags[ST_BLK] = done;
        if (en) begin
            if (to_host) begin
                flags[ST_RX_ACT]   = 1'b1;
                flags[ST_RX_HFULL] = f_hfull;
                flags[ST_RX_FULL]  = f_full;
                flags[ST_RX_EMPTY] = f_empty;
                flags[ST_RX_AVAIL] = f_avail;
            end else begin
                flags[ST_TX_ACT]   = 1'b1;
                flags[ST_TX_HEMP]  = f_hemp;
                flags[ST_TX_FULL]  = f_full;
                flags[ST_TX_EMPTY] = f_empty;
                flags[ST_TX_AVAIL] = f_avail;
            end
        end
    end
endmodule

// File: rtl/card_fifo_engine.sv
module card_fifo_engine
    import cfe_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int WORD_W = 32,
    parameter int LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [SEL_W-1:0]  host_addr,
    input  logic [WORD_W-1:0] host_wdata,
    output logic [WORD_W-1:0] host_rdata,
    input  logic              card_rdy,
    input  logic [7:0]        card_rx_byte,
    output logic              card_rx_take,
    output logic              card_tx_valid,
    output logic [7:0]        card_tx_byte,
    output logic              fifo_err
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic             en;
        logic             to_host;
        logic [LEN_W-1:0] len;
        logic [LEN_W-1:0] cnt;
        logic             defer;
        logic             done;
        logic             err;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [WORD_W-1:0] ring_head, ring_in;
    logic [CNT_W-1:0]  ring_fill;
    logic              ring_full, ring_empty, ring_push, ring_pop;
    logic              pk_push;
    logic [WORD_W-1:0] pk_word;
    logic              up_need, up_has;
    logic [7:0]        up_byte;
    logic [STAT_W-1:0] stat_flags;

    logic ctrl_wr, load, fifo_wr, fifo_rd, poll_rd;
    logic host_push, host_pop, push_rej, pop_rej;
    logic active, rx_step, tx_step, last_byte;
    logic [LEN_W:0] wcnt_sum;

    // signals also watched by the bound checker
    logic [LEN_W-1:0] byte_cnt;
    logic             xfer_en, defer_on;

    always_comb begin
        ctrl_wr   = host_wr && (host_addr == SEL_CTRL);
        load      = ctrl_wr && host_wdata[0];
        fifo_wr   = host_wr && (host_addr == SEL_FIFO);
        fifo_rd   = host_rd && (host_addr == SEL_FIFO);
        poll_rd   = host_rd && ((host_addr == SEL_STAT) || (host_addr == SEL_WCNT));

        host_push = fifo_wr && (ctl_q.cnt != '0) && !ctl_q.to_host && !ring_full;
        push_rej  = fifo_wr && (ctl_q.cnt != '0) && !ctl_q.to_host && ring_full;
        host_pop  = fifo_rd && !ring_empty;
        pop_rej   = fifo_rd && ring_empty;

        active    = ctl_q.en && (ctl_q.cnt != '0) && !ctl_q.defer && !ctrl_wr;
        last_byte = (ctl_q.cnt == LEN_W'(1));
        rx_step   = active && ctl_q.to_host && card_rdy && !ring_full;
        tx_step   = active && !ctl_q.to_host && (up_has || !ring_empty) && !host_pop;

        ring_push = host_push || pk_push;
        ring_in   = pk_push ? pk_word : host_wdata;
        ring_pop  = host_pop || (tx_step && up_need);

        card_rx_take  = rx_step;
        card_tx_valid = tx_step;
        card_tx_byte  = up_byte;
        fifo_err      = ctl_q.err;

        wcnt_sum = {1'b0, ctl_q.cnt} + (LEN_W + 1)'(3);

        unique case (host_addr)
            SEL_LEN:  host_rdata = WORD_W'(ctl_q.len);
            SEL_CTRL: host_rdata = WORD_W'({ctl_q.to_host, ctl_q.en});
            SEL_STAT: host_rdata = WORD_W'(stat_flags);
            SEL_WCNT: host_rdata = WORD_W'(wcnt_sum >> 2);
            SEL_FIFO: host_rdata = ring_empty ? '0 : ring_head;
            default:  host_rdata = '0;
        endcase

        ctl_d     = ctl_q;
        ctl_d.err = push_rej || pop_rej;

        if (host_wr && (host_addr == SEL_LEN)) begin
            ctl_d.len = host_wdata[LEN_W-1:0];
        end

        if (ctrl_wr) begin
            ctl_d.en      = host_wdata[0];
            ctl_d.to_host = host_wdata[1];
        end else if (ctl_q.en && (ctl_q.cnt == '0) && ring_empty) begin
            ctl_d.en = 1'b0;
        end

        if (load) begin
            ctl_d.cnt = ctl_q.len;
        end else if (rx_step || tx_step) begin
            ctl_d.cnt = ctl_q.cnt - 1'b1;
        end

        if (load) begin
            ctl_d.done = 1'b0;
        end else if (ctl_q.en && (ctl_q.cnt == '0)) begin
            ctl_d.done = 1'b1;
        end

        if (load) begin
            ctl_d.defer = 1'b0;
        end else if (host_pop) begin
            ctl_d.defer = 1'b1;
        end else if (poll_rd) begin
            ctl_d.defer = 1'b0;
        end

        byte_cnt = ctl_q.cnt;
        xfer_en  = ctl_q.en;
        defer_on = ctl_q.defer;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    cfe_word_ring #(.DEPTH(DEPTH), .WORD_W(WORD_W), .CNT_W(CNT_W)) u_ring (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (ring_push),
        .push_word (ring_in),
        .pop       (ring_pop),
        .head      (ring_head),
        .fill      (ring_fill),
        .full      (ring_full),
        .empty     (ring_empty)
    );

    cfe_packer #(.WORD_W(WORD_W)) u_pack (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (ctrl_wr),
        .step    (rx_step),
        .last    (last_byte),
        .byte_in (card_rx_byte),
        .push    (pk_push),
        .word    (pk_word)
    );

    cfe_unpacker #(.WORD_W(WORD_W)) u_unpack (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (ctrl_wr),
        .step      (tx_step),
        .last      (last_byte),
        .word_in   (ring_head),
        .need_word (up_need),
        .has_bytes (up_has),
        .byte_out  (up_byte)
    );

    cfe_status #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_stat (
        .en      (ctl_q.en),
        .to_host (ctl_q.to_host),
        .done    (ctl_q.done),
        .fill    (ring_fill),
        .flags   (stat_flags)
    );
endmodule

// File: rtl/cfe_checker.sv
module cfe_checker
    import cfe_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int LEN_W = 16,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             host_wr,
    input logic             host_rd,
    input logic [SEL_W-1:0] host_addr,
    input logic             card_rdy,
    input logic             card_rx_take,
    input logic             card_tx_valid,
    input logic             fifo_err,
    input logic             xfer_en,
    input logic             defer_on,
    input logic [LEN_W-1:0] byte_cnt,
    input logic [CNT_W-1:0] ring_fill
);
    p_fill_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ring_fill <= CNT_W'(DEPTH));

    p_one_way_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(card_rx_take && card_tx_valid));

    p_count_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (card_rx_take || card_tx_valid) |=> byte_cnt == LEN_W'($past(byte_cnt) - 1'b1));

    p_rx_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        card_rx_take |-> (card_rdy && ring_fill < CNT_W'(DEPTH)));

    p_self_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_en && byte_cnt == '0 && ring_fill == '0
         && !(host_wr && host_addr == SEL_CTRL)) |=> !xfer_en);

    p_defer_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        defer_on |-> (!card_rx_take && !card_tx_valid));

    p_pop_defers_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && host_addr == SEL_FIFO && ring_fill != '0
         && !(host_wr && host_addr == SEL_CTRL)) |=> defer_on);

    p_err_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && host_addr == SEL_FIFO && ring_fill == '0) |=> fifo_err);
endmodule

bind card_fifo_engine cfe_checker #(.DEPTH(DEPTH), .LEN_W(LEN_W), .CNT_W(CNT_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .host_wr       (host_wr),
    .host_rd       (host_rd),
    .host_addr     (host_addr),
    .card_rdy      (card_rdy),
    .card_rx_take  (card_rx_take),
    .card_tx_valid (card_tx_valid),
    .fifo_err      (fifo_err),
    .xfer_en       (xfer_en),
    .defer_on      (defer_on),
    .byte_cnt      (byte_cnt),
    .ring_fill     (ring_fill)
);

// File: tb/card_fifo_engine_tb.sv
module card_fifo_engine_tb;
    localparam logic [2:0] A_LEN = 3'd0, A_CTRL = 3'd1, A_STAT = 3'd2, A_WCNT = 3'd3, A_FIFO = 3'd4;
    localparam logic [31:0] S_RX_DONE8  = 32'h983;
    localparam logic [31:0] S_RX_FULL   = 32'hB80;
    localparam logic [31:0] S_RX_15     = 32'h980;
    localparam logic [31:0] S_RX_EMPTY  = 32'h480;
    localparam logic [31:0] S_TX_EMPTY  = 32'h02C;
    localparam logic [31:0] S_DONE      = 32'h003;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0, host_rd = 1'b0;
    logic [2:0]  host_addr = '0;
    logic [31:0] host_wdata = '0, host_rdata;
    logic        card_rdy = 1'b0;
    logic [7:0]  card_rx_byte;
    logic        card_rx_take, card_tx_valid;
    logic [7:0]  card_tx_byte;
    logic        fifo_err;

    int checks = 0;
    int errors = 0;
    int rx_idx = 0;
    int tx_n = 0;
    logic [7:0] tx_log [64];

    always #4 clk = ~clk;

    card_fifo_engine u_dut (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .card_rdy(card_rdy), .card_rx_byte(card_rx_byte), .card_rx_take(card_rx_take),
        .card_tx_valid(card_tx_valid), .card_tx_byte(card_tx_byte), .fifo_err(fifo_err)
    );

    function automatic logic [7:0] pat(input int i);
        return 8'((i * 7 + 3) & 255);
    endfunction

    function automatic logic [31:0] pword(input int first, input int nbytes);
        logic [31:0] w = '0;
        for (int j = 0; j < nbytes; j++) w[j*8 +: 8] = pat(first + j);
        return w;
    endfunction

    assign card_rx_byte = pat(rx_idx);

    initial begin
        logic ts;
        forever begin
            @(negedge clk);
            #2;
            ts = card_rx_take;
            if (card_tx_valid && tx_n < 64) begin
                tx_log[tx_n] = card_tx_byte;
                tx_n++;
            end
            @(posedge clk);
            #1;
            if (ts) rx_idx++;
        end
    end

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic hwrite(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic hread(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        host_addr = a; host_rd = 1'b1;
        #1 d = host_rdata;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        hread(A_STAT, v); chk("R8 reset status", v, 32'h0);
        hread(A_CTRL, v); chk("R5 reset control", v, 32'h0);
        hread(A_WCNT, v); chk("R10 reset word count", v, 32'h0);
        chk("R12 reset error", 32'(fifo_err), 32'h0);
    endtask

    task automatic t_rx_block;
        logic [31:0] v;
        int start = rx_idx;
        card_rdy = 1'b1;
        hwrite(A_LEN, 32);
        hwrite(A_CTRL, 3);
        idle(45);
        chk("R6 bytes taken", 32'(rx_idx - start), 32);
        hread(A_STAT, v); chk("R8 R7 rx half-full done status", v, S_RX_DONE8);
        hread(A_WCNT, v); chk("R10 word count at end", v, 0);
        for (int k = 0; k < 8; k++) begin
            hread(A_FIFO, v); chk("R2 packed word", v, pword(start + 4*k, 4));
            hread(A_STAT, v);
        end
        idle(2);
        hread(A_CTRL, v); chk("R7 enable self-clear", v, 32'h2);
        hread(A_STAT, v); chk("R7 done stays, flags off", v, S_DONE);
    endtask

    task automatic t_rx_partial;
        logic [31:0] v;
        int start = rx_idx;
        card_rdy = 1'b0;
        hwrite(A_LEN, 6);
        hwrite(A_CTRL, 3);
        hwrite(A_FIFO, 32'hDEADBEEF);
        idle(5);
        chk("R6 no take while not ready", 32'(rx_idx - start), 0);
        hread(A_STAT, v); chk("R11 rx-mode host write ignored", v, S_RX_EMPTY);
        hread(A_WCNT, v); chk("R10 word count rounding", v, 2);
        card_rdy = 1'b1;
        idle(12);
        hread(A_FIFO, v); chk("R2 first word", v, pword(start, 4));
        hread(A_STAT, v);
        hread(A_FIFO, v); chk("R3 padded last word", v, pword(start + 4, 2));
        hread(A_STAT, v);
        chk("R3 byte total", 32'(rx_idx - start), 6);
    endtask

    task automatic t_rx_full;
        logic [31:0] v;
        int start = rx_idx;
        card_rdy = 1'b1;
        hwrite(A_LEN, 80);
        hwrite(A_CTRL, 3);
        idle(100);
        chk("R6 stop at full", 32'(rx_idx - start), 64);
        hread(A_STAT, v); chk("R1 R8 full status", v, S_RX_FULL);
        hread(A_WCNT, v); chk("R10 word count mid", v, 4);
        hread(A_FIFO, v); chk("R1 head word", v, pword(start, 4));
        idle(10);
        chk("R9 deferred after pop", 32'(rx_idx - start), 64);
        hread(A_STAT, v); chk("R9 status captured before resume", v, S_RX_15);
        idle(10);
        chk("R9 resumed after poll", 32'(rx_idx - start), 68);
        for (int k = 1; k < 20; k++) begin
            hread(A_FIFO, v); chk("R1 order after wrap", v, pword(start + 4*k, 4));
            if (k % 2 == 1) hread(A_STAT, v);
            else            hread(A_WCNT, v);
            idle(6);
        end
        chk("R9 all bytes moved", 32'(rx_idx - start), 80);
        hread(A_CTRL, v); chk("R7 enable cleared after drain", v, 32'h2);
    endtask

    task automatic t_tx;
        logic [31:0] v;
        card_rdy = 1'b0;
        tx_n = 0;
        hwrite(A_LEN, 32'h0001_0006);
        hread(A_LEN, v); chk("R5 length keeps 16 bits", v, 32'h6);
        hwrite(A_CTRL, 1);
        hread(A_STAT, v); chk("R8 tx empty status", v, S_TX_EMPTY);
        hwrite(A_FIFO, 32'hA3A2A1A0);
        hwrite(A_FIFO, 32'hB3B2B1B0);
        idle(12);
        chk("R4 byte count sent", 32'(tx_n), 6);
        chk("R4 byte 0", 32'(tx_log[0]), 32'hA0);
        chk("R4 byte 3", 32'(tx_log[3]), 32'hA3);
        chk("R4 byte 4", 32'(tx_log[4]), 32'hB0);
        chk("R4 byte 5", 32'(tx_log[5]), 32'hB1);
        hread(A_STAT, v); chk("R7 tx done status", v, S_DONE);
        hread(A_CTRL, v); chk("R7 tx enable cleared", v, 32'h0);
    endtask

    task automatic t_errors;
        logic [31:0] v;
        hwrite(A_FIFO, 32'h12345678);
        hread(A_STAT, v); chk("R11 write at zero count ignored", v, S_DONE);
        chk("R12 no error on ignored write", 32'(fifo_err), 32'h0);
        hread(A_FIFO, v); chk("R11 empty read returns zero", v, 32'h0);
        chk("R12 error pulse", 32'(fifo_err), 32'h1);
        idle(1);
        chk("R12 pulse ends", 32'(fifo_err), 32'h0);
        chk("R4 nothing sent", 32'(tx_n), 6);
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        idle(4);
        rst_n = 1'b1;
        idle(2);
        t_reset();
        t_rx_block();
        t_rx_partial();
        t_rx_full();
        t_tx();
        t_errors();
        idle(3);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule